// File: doc/BRIEF.md
# Symmetrical Component Voltage Calculator

This block takes the fundamental-frequency phasors of the three phase-to-earth voltages L1, L2 and L3 and splits them into their symmetrical components. Each phasor arrives as a signed fixed-point real and imaginary part. The block computes three results: the positive sequence voltage, the negative sequence voltage, and the zero sequence voltage scaled by three. Each result is given both as a complex phasor and as a cheap magnitude estimate that later threshold logic can compare against settings.

A strobe marks the input set to be processed. The pipeline accepts a new set on every clock, and a matching strobe comes out a fixed number of cycles later. Rotation by the 120° operator and by its square uses constant multipliers in Q1.15. Division by three uses a Q0.16 reciprocal. Every rounding step rounds to nearest, with ties going toward positive infinity, which equals adding half an LSB and then taking the floor. Phasor estimation from raw samples, and any protection decision, belong to other blocks.

Top module: `seq_volt_calc`

## Requirements
- R1: `out_valid` is high exactly three clock cycles after each cycle in which `in_valid` was sampled high, and never otherwise. Inputs presented on consecutive cycles each produce their own result on consecutive cycles.
- R2: A synchronous active-high `rst` clears `out_valid` and every data output to zero on the next clock edge. An input accepted before the reset never emerges afterwards.
- R3: The zero sequence output equals the exact sum L1+L2+L3 of the real parts and of the imaginary parts, sign-extended to W+2 bits, with no division.
- R4: A phasor x+jy is rotated by +120° as re = floor((-16384·x - 28378·y + 16384)/32768) and im = floor((28378·x - 16384·y + 16384)/32768). Rotation by +240° uses the same formula with -28378 in place of 28378.
- R5: The positive sequence output equals floor((S·21845 + 32768)/65536), computed separately for the real and imaginary parts, where S = L1 + rot120(L2) + rot240(L3).
- R6: The negative sequence output uses the same scaling applied to S = L1 + rot240(L2) + rot120(L3). This phase ordering is distinct from that of R5.
- R7: Each magnitude output equals max(|re|,|im|) + floor(min(|re|,|im|)/2) of the phasor that is output in the same cycle, as an unsigned W+3 bit value.
- R8: Input data presented while `in_valid` is low produces no `out_valid` pulse.
- R9: No output wraps around for any input values, including full-scale negative values on every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input phasor set is valid this cycle |
| l1_re | input | W | L1 real part, signed |
| l1_im | input | W | L1 imaginary part, signed |
| l2_re | input | W | L2 real part, signed |
| l2_im | input | W | L2 imaginary part, signed |
| l3_re | input | W | L3 real part, signed |
| l3_im | input | W | L3 imaginary part, signed |
| out_valid | output | 1 | Results valid this cycle |
| pos_re | output | W+2 | Positive sequence real part, signed |
| pos_im | output | W+2 | Positive sequence imaginary part, signed |
| neg_re | output | W+2 | Negative sequence real part, signed |
| neg_im | output | W+2 | Negative sequence imaginary part, signed |
| zero_re | output | W+2 | Triple zero sequence real part, signed |
| zero_im | output | W+2 | Triple zero sequence imaginary part, signed |
| pos_mag | output | W+3 | Positive sequence magnitude estimate |
| neg_mag | output | W+3 | Negative sequence magnitude estimate |
| zero_mag | output | W+3 | Zero sequence magnitude estimate |

## Verification
Three properties are checked on every cycle. The strobe must track a three-cycle delayed copy of the input strobe, the outputs must be clear right after reset, and each magnitude must lie between the larger component and the sum of both components of its phasor. The bench's directed scenarios are needed for the rest. Only they can show the exact arithmetic of the rotations and the division by three, the phase ordering that separates the positive result from the negative one, and freedom from wraparound at full-scale inputs. They also show that a reset discards a set already in flight. They use balanced positive-only, negative-only and zero-only sets as well as mixed and back-to-back streams.

// File: rtl/svc_pkg.sv
package svc_pkg;
  // Rotation constants: cos120 = -0.5, sin120 = +0.866 in Q1.15
  localparam int COEF_FRAC = 15;
  localparam int SIN120_Q  = 28378;
  // Division by three: reciprocal in Q0.16
  localparam int RECIP_FRAC = 16;
  localparam int RECIP3_Q   = 21845;
  // Number of sequence results (positive, negative, zero)
  localparam int NUM_SEQ = 3;
  localparam int SEQ_POS  = 0;
  localparam int SEQ_NEG  = 1;
  localparam int SEQ_ZERO = 2;
endpackage

// File: rtl/svc_rotate.sv
// Multiplies a phasor by the unit phasor at +120 (NEG_SIN=0) or +240 (NEG_SIN=1).
module svc_rotate import svc_pkg::*; #(
  parameter int W       = 16,
  parameter bit NEG_SIN = 1'b0
) (
  input  logic signed [W-1:0] x_re,
  input  logic signed [W-1:0] x_im,
  output logic signed [W:0]   y_re,
  output logic signed [W:0]   y_im
);
  localparam int PW = W + COEF_FRAC + 3;
  localparam int SV = NEG_SIN ? -SIN120_Q : SIN120_Q;
  localparam logic signed [PW-1:0] SK  = PW'(SV);
  localparam logic signed [PW-1:0] CK  = PW'(-(1 << (COEF_FRAC - 1)));
  localparam logic signed [PW-1:0] RND = PW'(1 << (COEF_FRAC - 1));

  logic signed [PW-1:0] xe, ye, acc_re, acc_im;

  assign xe     = PW'(x_re);
  assign ye     = PW'(x_im);
  assign acc_re = xe * CK - ye * SK;
  assign acc_im = xe * SK + ye * CK;
  assign y_re   = (W+1)'((acc_re + RND) >>> COEF_FRAC);
  assign y_im   = (W+1)'((acc_im + RND) >>> COEF_FRAC);
endmodule

// File: rtl/svc_third.sv
// Divides a signed value by three through a rounded reciprocal multiply.
module svc_third import svc_pkg::*; #(
  parameter int IW = 19,
  parameter int OW = 18
) (
  input  logic signed [IW-1:0] s,
  output logic signed [OW-1:0] q
);
  localparam int PW = IW + RECIP_FRAC + 2;
  localparam logic signed [PW-1:0] RK  = PW'(RECIP3_Q);
  localparam logic signed [PW-1:0] RND = PW'(1 << (RECIP_FRAC - 1));

  logic signed [PW-1:0] se;

  assign se = PW'(s);
  assign q  = OW'((se * RK + RND) >>> RECIP_FRAC);
endmodule

// File: rtl/svc_mag.sv
// Magnitude estimate: larger component plus half of the smaller one.
module svc_mag #(
  parameter int OW = 18
) (
  input  logic signed [OW-1:0] re,
  input  logic signed [OW-1:0] im,
  output logic [OW:0]          mag
);
  logic signed [OW:0] re_e, im_e;
  logic [OW:0] ar, ai, mx, mn;

  always_comb begin
    re_e = (OW+1)'(re);
    im_e = (OW+1)'(im);
    ar   = (re_e < 0) ? -re_e : re_e;
    ai   = (im_e < 0) ? -im_e : im_e;
    mx   = (ar >= ai) ? ar : ai;
    mn   = (ar >= ai) ? ai : ar;
    mag  = mx + (mn >> 1);
  end
endmodule

// File: rtl/seq_volt_calc.sv
module seq_volt_calc import svc_pkg::*; #(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  l1_re,
  input  logic signed [W-1:0]  l1_im,
  input  logic signed [W-1:0]  l2_re,
  input  logic signed [W-1:0]  l2_im,
  input  logic signed [W-1:0]  l3_re,
  input  logic signed [W-1:0]  l3_im,
  output logic                 out_valid,
  output logic signed [W+1:0]  pos_re,
  output logic signed [W+1:0]  pos_im,
  output logic signed [W+1:0]  neg_re,
  output logic signed [W+1:0]  neg_im,
  output logic signed [W+1:0]  zero_re,
  output logic signed [W+1:0]  zero_im,
  output logic [W+2:0]         pos_mag,
  output logic [W+2:0]         neg_mag,
  output logic [W+2:0]         zero_mag
);
  localparam int RW   = W + 1;  // rotated phasor width
  localparam int SW   = W + 3;  // three-term sum width
  localparam int OW   = W + 2;  // output phasor width
  localparam int NROT = 4;

  // Rotations: 0 = a*L2, 1 = a2*L3 (positive); 2 = a2*L2, 3 = a*L3 (negative)
  logic signed [RW-1:0] rot_re [NROT];
  logic signed [RW-1:0] rot_im [NROT];

  for (genvar k = 0; k < NROT; k++) begin : g_rot
    svc_rotate #(.W(W), .NEG_SIN((k == 1) || (k == 2))) u_rot (
      .x_re ((k % 2 == 0) ? l2_re : l3_re),
      .x_im ((k % 2 == 0) ? l2_im : l3_im),
      .y_re (rot_re[k]),
      .y_im (rot_im[k])
    );
  end

  // Stage 1 registers
  logic                 s1_v;
  logic signed [W-1:0]  s1_l1_re, s1_l1_im;
  logic signed [RW-1:0] s1_rot_re [NROT];
  logic signed [RW-1:0] s1_rot_im [NROT];
  logic signed [OW-1:0] s1_z_re, s1_z_im;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_l1_re <= '0;
      s1_l1_im <= '0;
      s1_z_re  <= '0;
      s1_z_im  <= '0;
      for (int k = 0; k < NROT; k++) begin
        s1_rot_re[k] <= '0;
        s1_rot_im[k] <= '0;
      end
    end else begin
      s1_v     <= in_valid;
      s1_l1_re <= l1_re;
      s1_l1_im <= l1_im;
      s1_z_re  <= OW'(l1_re) + OW'(l2_re) + OW'(l3_re);
      s1_z_im  <= OW'(l1_im) + OW'(l2_im) + OW'(l3_im);
      for (int k = 0; k < NROT; k++) begin
        s1_rot_re[k] <= rot_re[k];
        s1_rot_im[k] <= rot_im[k];
      end
    end
  end

  // Stage 2: three-term sums and division by three
  logic signed [SW-1:0] sum_re [2];
  logic signed [SW-1:0] sum_im [2];
  logic signed [OW-1:0] thr_re [2];
  logic signed [OW-1:0] thr_im [2];

  for (genvar j = 0; j < 2; j++) begin : g_seq
    assign sum_re[j] = SW'(s1_l1_re) + SW'(s1_rot_re[2*j]) + SW'(s1_rot_re[2*j+1]);
    assign sum_im[j] = SW'(s1_l1_im) + SW'(s1_rot_im[2*j]) + SW'(s1_rot_im[2*j+1]);

    svc_third #(.IW(SW), .OW(OW)) u_third_re (.s(sum_re[j]), .q(thr_re[j]));
    svc_third #(.IW(SW), .OW(OW)) u_third_im (.s(sum_im[j]), .q(thr_im[j]));
  end

  logic                 s2_v;
  logic signed [OW-1:0] s2_re [NUM_SEQ];
  logic signed [OW-1:0] s2_im [NUM_SEQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0;
      for (int n = 0; n < NUM_SEQ; n++) begin
        s2_re[n] <= '0;
        s2_im[n] <= '0;
      end
    end else begin
      s2_v            <= s1_v;
      s2_re[SEQ_POS]  <= thr_re[0];
      s2_im[SEQ_POS]  <= thr_im[0];
      s2_re[SEQ_NEG]  <= thr_re[1];
      s2_im[SEQ_NEG]  <= thr_im[1];
      s2_re[SEQ_ZERO] <= s1_z_re;
      s2_im[SEQ_ZERO] <= s1_z_im;
    end
  end

  // Stage 3: magnitude estimates and output registers
  logic [OW:0] mag_c [NUM_SEQ];

  for (genvar n = 0; n < NUM_SEQ; n++) begin : g_mag
    svc_mag #(.OW(OW)) u_mag (.re(s2_re[n]), .im(s2_im[n]), .mag(mag_c[n]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      pos_re    <= '0;
      pos_im    <= '0;
      neg_re    <= '0;
      neg_im    <= '0;
      zero_re   <= '0;
      zero_im   <= '0;
      pos_mag   <= '0;
      neg_mag   <= '0;
      zero_mag  <= '0;
    end else begin
      out_valid <= s2_v;
      pos_re    <= s2_re[SEQ_POS];
      pos_im    <= s2_im[SEQ_POS];
      neg_re    <= s2_re[SEQ_NEG];
      neg_im    <= s2_im[SEQ_NEG];
      zero_re   <= s2_re[SEQ_ZERO];
      zero_im   <= s2_im[SEQ_ZERO];
      pos_mag   <= mag_c[SEQ_POS];
      neg_mag   <= mag_c[SEQ_NEG];
      zero_mag  <= mag_c[SEQ_ZERO];
    end
  end
endmodule

// File: rtl/svc_checker.sv
module svc_checker #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                out_valid,
  input logic signed [W+1:0] pos_re,
  input logic signed [W+1:0] pos_im,
  input logic signed [W+1:0] neg_re,
  input logic signed [W+1:0] neg_im,
  input logic signed [W+1:0] zero_re,
  input logic signed [W+1:0] zero_im,
  input logic [W+2:0]        pos_mag,
  input logic [W+2:0]        neg_mag,
  input logic [W+2:0]        zero_mag
);
  logic [2:0] vdly;
  logic       rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) vdly <= '0;
    else     vdly <= {vdly[1:0], in_valid};
  end

  function automatic logic [W+2:0] absv(logic signed [W+1:0] v);
    logic signed [W+2:0] e;
    e = (W+3)'(v);
    return (e < 0) ? -e : e;
  endfunction

  function automatic logic [W+2:0] maxv(logic [W+2:0] a, logic [W+2:0] b);
    return (a >= b) ? a : b;
  endfunction

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid == vdly[2]);

  assert_reset_clear_R2: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (!out_valid && pos_re == 0 && neg_im == 0 && zero_re == 0 && pos_mag == 0));

  assert_pos_mag_bounds_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pos_mag >= maxv(absv(pos_re), absv(pos_im)) &&
                   pos_mag <= absv(pos_re) + absv(pos_im)));

  assert_neg_mag_bounds_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (neg_mag >= maxv(absv(neg_re), absv(neg_im)) &&
                   neg_mag <= absv(neg_re) + absv(neg_im)));

  assert_zero_mag_bounds_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (zero_mag >= maxv(absv(zero_re), absv(zero_im)) &&
                   zero_mag <= absv(zero_re) + absv(zero_im)));
endmodule

bind seq_volt_calc svc_checker #(.W(W)) u_svc_checker (.*);

// File: tb/test_seq_volt_calc.sv
module test_seq_volt_calc;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;

  typedef longint res_t [9];

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] l1_re = '0, l1_im = '0, l2_re = '0, l2_im = '0, l3_re = '0, l3_im = '0;
  logic out_valid;
  logic signed [W+1:0] pos_re, pos_im, neg_re, neg_im, zero_re, zero_im;
  logic [W+2:0] pos_mag, neg_mag, zero_mag;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_volt_calc #(.W(W)) i_seq_volt_calc (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .l1_re(l1_re), .l1_im(l1_im), .l2_re(l2_re), .l2_im(l2_im),
    .l3_re(l3_re), .l3_im(l3_im), .out_valid(out_valid),
    .pos_re(pos_re), .pos_im(pos_im), .neg_re(neg_re), .neg_im(neg_im),
    .zero_re(zero_re), .zero_im(zero_im),
    .pos_mag(pos_mag), .neg_mag(neg_mag), .zero_mag(zero_mag)
  );

  // ---------------- reference model from the requirements ----------------
  function automatic longint rnd15(longint v);
    return (v + 16384) >>> 15;
  endfunction

  // R4: rotation by +120 (neg=0) or +240 (neg=1)
  function automatic void rot(longint x, longint y, bit neg, output longint re, output longint im);
    longint s;
    s  = neg ? -28378 : 28378;
    re = rnd15(-16384 * x - s * y);
    im = rnd15(s * x - 16384 * y);
  endfunction

  function automatic longint third(longint v);
    return (v * 21845 + 32768) >>> 16;
  endfunction

  function automatic longint magm(longint re, longint im);
    longint ar, ai, mx, mn;
    ar = (re < 0) ? -re : re;
    ai = (im < 0) ? -im : im;
    mx = (ar >= ai) ? ar : ai;
    mn = (ar >= ai) ? ai : ar;
    return mx + (mn >>> 1);
  endfunction

  function automatic res_t model(longint a, longint b, longint c, longint d, longint e, longint f);
    res_t r;
    longint r0re, r0im, r1re, r1im, r2re, r2im, r3re, r3im;
    rot(c, d, 1'b0, r0re, r0im);
    rot(e, f, 1'b1, r1re, r1im);
    rot(c, d, 1'b1, r2re, r2im);
    rot(e, f, 1'b0, r3re, r3im);
    r[0] = third(a + r0re + r1re);
    r[1] = third(b + r0im + r1im);
    r[2] = third(a + r2re + r3re);
    r[3] = third(b + r2im + r3im);
    r[4] = a + c + e;
    r[5] = b + d + f;
    r[6] = magm(r[0], r[1]);
    r[7] = magm(r[2], r[3]);
    r[8] = magm(r[4], r[5]);
    return r;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(string scen, string tag, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", scen, tag, what, act, exp);
    end
  endtask

  task automatic chk_res(string scen, res_t e);
    string fld [9] = '{"pos_re", "pos_im", "neg_re", "neg_im", "zero_re", "zero_im",
                       "pos_mag", "neg_mag", "zero_mag"};
    string tg  [9] = '{"R5", "R5", "R6", "R6", "R3", "R3", "R7", "R7", "R7"};
    res_t a;
    a[0] = longint'(pos_re);  a[1] = longint'(pos_im);
    a[2] = longint'(neg_re);  a[3] = longint'(neg_im);
    a[4] = longint'(zero_re); a[5] = longint'(zero_im);
    a[6] = longint'(pos_mag); a[7] = longint'(neg_mag); a[8] = longint'(zero_mag);
    for (int k = 0; k < 9; k++) chk(scen, tg[k], fld[k], a[k], e[k]);
  endtask

  task automatic drive(longint a, longint b, longint c, longint d, longint e, longint f);
    l1_re = W'(a); l1_im = W'(b); l2_re = W'(c); l2_im = W'(d); l3_re = W'(e); l3_im = W'(f);
  endtask

  // One set in, result checked three cycles later (R1 timing plus data)
  task automatic run_one(string scen, longint a, longint b, longint c, longint d, longint e, longint f);
    res_t ex;
    ex = model(a, b, c, d, e, f);
    @(negedge clk);
    drive(a, b, c, d, e, f);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    drive(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(scen, "R1", "out_valid early", longint'(out_valid), 0);
    @(negedge clk);
    chk(scen, "R1", "out_valid at latency 3", longint'(out_valid), 1);
    chk_res(scen, ex);
    @(negedge clk);
    chk(scen, "R1", "out_valid single pulse", longint'(out_valid), 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst = 1'b1;
    in_valid = 1'b1;
    drive(1234, -999, 500, 700, -300, 42);
    repeat (4) @(negedge clk);
    chk("reset", "R2", "out_valid", longint'(out_valid), 0);
    chk("reset", "R2", "pos_re", longint'(pos_re), 0);
    chk("reset", "R2", "neg_im", longint'(neg_im), 0);
    chk("reset", "R2", "zero_mag", longint'(zero_mag), 0);
    in_valid = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("reset", "R2", "out_valid after release", longint'(out_valid), 0);
  endtask

  task automatic t_positive_only();
    // balanced set rotating forward: L2 = a2*L1, L3 = a*L1
    run_one("positive_only", 10000, 0, -5000, -8660, -5000, 8660);
  endtask

  task automatic t_negative_only();
    // swapped ordering: result lands in the negative output (R6)
    run_one("negative_only", 10000, 0, -5000, 8660, -5000, -8660);
  endtask

  task automatic t_zero_only();
    run_one("zero_only", 8000, -3000, 8000, -3000, 8000, -3000);
  endtask

  task automatic t_mixed();
    run_one("mixed", 12345, -2222, -7777, 3141, 271, -16000);
    run_one("mixed_small", 1, -1, 1, 1, -1, 1);
  endtask

  task automatic t_extremes();
    // R9: full-scale values, no wraparound
    run_one("extreme_neg", -32768, -32768, -32768, -32768, -32768, -32768);
    run_one("extreme_mix", -32768, 32767, 32767, -32768, -32768, 32767);
    run_one("extreme_pos", 32767, 32767, -32768, 32767, 32767, -32768);
  endtask

  task automatic t_stream();
    res_t ex [5];
    for (int i = 0; i < 5; i++)
      ex[i] = model(3000*i - 6000, 1700 - 900*i, 250*i, -4000 + 1100*i, 20000 - 7000*i, 333*i);
    for (int i = 0; i <= 8; i++) begin
      @(negedge clk);
      if (i >= 3 && i < 8) begin
        chk("stream", "R1", "out_valid back-to-back", longint'(out_valid), 1);
        chk_res("stream", ex[i-3]);
      end
      if (i == 8) chk("stream", "R1", "out_valid after stream", longint'(out_valid), 0);
      if (i < 5) begin
        drive(3000*i - 6000, 1700 - 900*i, 250*i, -4000 + 1100*i, 20000 - 7000*i, 333*i);
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_idle();
    // R8: data changes without the strobe never produce a result
    in_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      drive(1000 + i, -2000 * i, 77, i, -5, 9000);
      chk("idle", "R8", "out_valid without strobe", longint'(out_valid), 0);
    end
  endtask

  task automatic t_reset_inflight();
    // R2: a set accepted before reset never emerges
    @(negedge clk);
    drive(5000, 5000, 5000, 5000, 5000, 5000);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("reset_inflight", "R2", "out_valid", longint'(out_valid), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    t_reset();
    t_positive_only();
    t_negative_only();
    t_zero_only();
    t_mixed();
    t_extremes();
    t_stream();
    t_idle();
    t_reset_inflight();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule